// File: doc/BRIEF.md
# Clock Output Enable and Routing Control

This block decides, for each of eleven clock output channels, whether the channel toggles and which clock source it carries. Ten of the channels form two groups of five. Each group has its own post-divider, and the divider input is either the PLL clock or the raw reference clock. The last channel carries the raw reference clock directly and never goes through the PLL or a divider.

Each channel's enable combines several configuration inputs: a chip enable, an enable for each group divider, an enable for each output, a bypass select for each group, the PLL lock status and a lock-override bit. An enable changes only while the channel's source clock is low. This keeps pulses at full width. A change of divider source is made in three steps: the group's outputs are first quiesced, then the select is switched, then the outputs are re-enabled. The clock levels are inputs sampled on the control clock, and the block models only this glitch-free enable timing.

Top module: `clkout_route_ctl`

## Requirements
- R1: The direct channel is index 10 (`ch_src_ref[10]` is always 1). Its desired enable is `chip_en & out_en[10]`, and it does not depend on lock status, lock override or PLL enable.
- R2: Group g occupies channels g*5 to g*5+4. `grp_src_ref[g]` (1 = raw reference, 0 = PLL, reset 0) follows `grp_bypass[g]` only once every channel of the group is disabled. With the source levels low, a bypass change disables the group at edge 1, switches the select at edge 2 and re-enables at edge 3. `ch_src_ref` of a group channel equals `grp_src_ref` of its group.
- R3: When `grp_div_en[g]` is 0, all five channels of group g are disabled.
- R4: When `out_en[i]` is 0, channel i is disabled, and no other channel is affected.
- R5: When `chip_en` is 0, all channels are disabled and `pll_pwr_on` is 0.
- R6: `pll_pwr_on` equals `pll_en & chip_en`. When `pll_en` is 0, the PLL is treated as unlocked.
- R7: A group whose select is the PLL is disabled while the PLL is unlocked, unless `lock_ovr` is 1. A bypassed group is not gated by lock.
- R8: `lock_status` goes high one clock after `pll_locked & pll_en & chip_en` becomes true, and goes low one clock after it becomes false.
- R9: A channel enable changes only at a control-clock edge where that channel's source level is sampled low.
- R10: `ch_clk[i]` follows its source level while the channel is enabled, and is held low while it is disabled.
- R11: During reset, all channel enables, `lock_status` and the group selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable; 0 means quiescent |
| pll_en | input | 1 | PLL power enable |
| lock_ovr | input | 1 | Ignore lock status for PLL-fed groups |
| pll_locked | input | 1 | Lock indication from the PLL |
| grp_div_en | input | 2 | Divider enable for each group |
| grp_bypass | input | 2 | Requested divider source for each group (1 = raw reference) |
| out_en | input | 11 | Enable for each channel |
| grp_clk_lvl | input | 2 | Sampled level of each group's divided clock |
| ref_clk_lvl | input | 1 | Sampled level of the raw reference clock |
| pll_pwr_on | output | 1 | PLL power control |
| lock_status | output | 1 | Registered lock indication |
| grp_src_ref | output | 2 | Applied divider source select for each group |
| ch_src_ref | output | 11 | Source for each channel (1 = raw reference) |
| ch_en | output | 11 | Glitch-safe enable for each channel |
| ch_clk | output | 11 | Gated clock level for each channel |

## Verification
The bench holds a group clock high while it removes an enable. A design that gated immediately would cut the pulse short, and the bench sees the enable drop too early. A bypass change is followed edge by edge. A design that flipped the select while the outputs were live, or that never re-enabled them, fails the three-step order. Lock loss is applied with and without override and with one group bypassed. A design that gated the direct channel or a bypassed group by lock, or that ignored PLL enable as a lock qualifier, shows the wrong enable pattern. The bench also checks that disabled channels stay low while their source is high.

// File: rtl/clkout_route_pkg.sv
package clkout_route_pkg;

    typedef enum logic {
        SRC_PLL = 1'b0,
        SRC_REF = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic     div_en;
        logic     bypass_req;
        clk_src_e sel;
    } grp_ctl_t;

    function automatic int unsigned grp_of(input int unsigned ch, input int unsigned size);
        return ch / size;
    endfunction

endpackage

// File: rtl/clkout_route_want.sv
module clkout_route_want
    import clkout_route_pkg::*;
#(
    parameter int unsigned GRP_CNT  = 2,
    parameter int unsigned GRP_SIZE = 5,
    localparam int unsigned CH_CNT  = GRP_CNT * GRP_SIZE + 1
) (
    input  logic                chip_en,
    input  logic                lock_ok,
    input  logic                lock_ovr,
    input  grp_ctl_t            grp_ctl [GRP_CNT],
    input  logic [CH_CNT-1:0]   out_en,
    output logic [CH_CNT-1:0]   want
);
    localparam int unsigned DIR = CH_CNT - 1;

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        logic src_settled;
        logic lock_pass;
        logic grp_ok;
        assign src_settled = (grp_ctl[g].sel == clk_src_e'(grp_ctl[g].bypass_req));
        assign lock_pass   = (grp_ctl[g].sel == SRC_REF) | lock_ovr | lock_ok;
        assign grp_ok      = chip_en & grp_ctl[g].div_en & src_settled & lock_pass;
        for (genvar k = 0; k < GRP_SIZE; k++) begin : g_ch
            assign want[g*GRP_SIZE + k] = grp_ok & out_en[g*GRP_SIZE + k];
        end
    end

    assign want[DIR] = chip_en & out_en[DIR];

endmodule

// File: rtl/clkout_route_grpsel.sv
module clkout_route_grpsel
    import clkout_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bypass_req,
    input  logic     grp_quiet,
    output clk_src_e sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SRC_PLL;
        end else if (grp_quiet && (sel != clk_src_e'(bypass_req))) begin
            sel <= clk_src_e'(bypass_req);
        end
    end
endmodule

// File: rtl/clkout_route_gate.sv
module clkout_route_gate (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic src_lvl,
    output logic en,
    output logic clk_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (!src_lvl) begin
            en <= want;
        end
    end

    assign clk_out = en & src_lvl;
endmodule

// File: rtl/clkout_route_ctl.sv
module clkout_route_ctl
    import clkout_route_pkg::*;
#(
    parameter int unsigned GRP_CNT  = 2,
    parameter int unsigned GRP_SIZE = 5,
    localparam int unsigned CH_CNT  = GRP_CNT * GRP_SIZE + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chip_en,
    input  logic                pll_en,
    input  logic                lock_ovr,
    input  logic                pll_locked,
    input  logic [GRP_CNT-1:0]  grp_div_en,
    input  logic [GRP_CNT-1:0]  grp_bypass,
    input  logic [CH_CNT-1:0]   out_en,
    input  logic [GRP_CNT-1:0]  grp_clk_lvl,
    input  logic                ref_clk_lvl,
    output logic                pll_pwr_on,
    output logic                lock_status,
    output logic [GRP_CNT-1:0]  grp_src_ref,
    output logic [CH_CNT-1:0]   ch_src_ref,
    output logic [CH_CNT-1:0]   ch_en,
    output logic [CH_CNT-1:0]   ch_clk
);
    localparam int unsigned DIR = CH_CNT - 1;

    logic                lock_ok;
    logic [CH_CNT-1:0]   want;
    logic [CH_CNT-1:0]   src_lvl;
    grp_ctl_t            grp_ctl [GRP_CNT];

    assign pll_pwr_on = pll_en & chip_en;
    assign lock_ok    = pll_locked & pll_pwr_on;

    always_ff @(posedge clk) begin
        if (rst) lock_status <= 1'b0;
        else     lock_status <= lock_ok;
    end

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        clk_src_e sel;
        clkout_route_grpsel u_sel (
            .clk        (clk),
            .rst        (rst),
            .bypass_req (grp_bypass[g]),
            .grp_quiet  (~|ch_en[g*GRP_SIZE +: GRP_SIZE]),
            .sel        (sel)
        );
        assign grp_ctl[g]     = '{div_en: grp_div_en[g], bypass_req: grp_bypass[g], sel: sel};
        assign grp_src_ref[g] = (sel == SRC_REF);
    end

    clkout_route_want #(.GRP_CNT(GRP_CNT), .GRP_SIZE(GRP_SIZE)) u_want (
        .chip_en  (chip_en),
        .lock_ok  (lock_ok),
        .lock_ovr (lock_ovr),
        .grp_ctl  (grp_ctl),
        .out_en   (out_en),
        .want     (want)
    );

    for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
        if (c == DIR) begin : g_dir
            assign src_lvl[c]    = ref_clk_lvl;
            assign ch_src_ref[c] = 1'b1;
        end else begin : g_div
            localparam int unsigned G = grp_of(c, GRP_SIZE);
            assign src_lvl[c]    = grp_clk_lvl[G];
            assign ch_src_ref[c] = grp_src_ref[G];
        end
        clkout_route_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .want    (want[c]),
            .src_lvl (src_lvl[c]),
            .en      (ch_en[c]),
            .clk_out (ch_clk[c])
        );
    end

endmodule

// File: rtl/clkout_route_chk.sv
module clkout_route_chk #(
    parameter int unsigned GRP_CNT  = 2,
    parameter int unsigned GRP_SIZE = 5,
    localparam int unsigned CH_CNT  = GRP_CNT * GRP_SIZE + 1
) (
    input logic                clk,
    input logic                rst,
    input logic                chip_en,
    input logic                pll_en,
    input logic                lock_ovr,
    input logic                pll_locked,
    input logic [CH_CNT-1:0]   out_en,
    input logic [GRP_CNT-1:0]  grp_clk_lvl,
    input logic                ref_clk_lvl,
    input logic                lock_status,
    input logic [GRP_CNT-1:0]  grp_src_ref,
    input logic [CH_CNT-1:0]   ch_en
);
    localparam int unsigned DIR = CH_CNT - 1;

    AST_DIRECT_NO_LOCK_GATE: assert property (@(posedge clk) disable iff (rst)
        (chip_en && out_en[DIR] && !ref_clk_lvl) |=> ch_en[DIR]); // R1

    AST_CHIP_OFF_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (!chip_en && !ref_clk_lvl) |=> !ch_en[DIR]); // R5

    AST_PLL_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        !pll_en |=> !lock_status); // R6

    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (pll_locked && pll_en && chip_en) |=> lock_status); // R8

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        AST_SRC_SWITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
            !$stable(grp_src_ref[g]) |-> $past(ch_en[g*GRP_SIZE +: GRP_SIZE]) == '0); // R2

        AST_UNLOCK_GATES: assert property (@(posedge clk) disable iff (rst)
            (!pll_locked && !lock_ovr && !grp_src_ref[g] && !grp_clk_lvl[g])
            |=> ch_en[g*GRP_SIZE +: GRP_SIZE] == '0); // R7
    end

    for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
        if (c == DIR) begin : g_dir
            AST_EN_CHANGE_LOW: assert property (@(posedge clk) disable iff (rst)
                !$stable(ch_en[c]) |-> !$past(ref_clk_lvl)); // R9
        end else begin : g_div
            AST_EN_CHANGE_LOW: assert property (@(posedge clk) disable iff (rst)
                !$stable(ch_en[c]) |-> !$past(grp_clk_lvl[c / GRP_SIZE])); // R9
        end
    end
endmodule

bind clkout_route_ctl clkout_route_chk #(.GRP_CNT(GRP_CNT), .GRP_SIZE(GRP_SIZE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chip_en     (chip_en),
    .pll_en      (pll_en),
    .lock_ovr    (lock_ovr),
    .pll_locked  (pll_locked),
    .out_en      (out_en),
    .grp_clk_lvl (grp_clk_lvl),
    .ref_clk_lvl (ref_clk_lvl),
    .lock_status (lock_status),
    .grp_src_ref (grp_src_ref),
    .ch_en       (ch_en)
);

// File: tb/sim_clkout_route_ctl.sv
module sim_clkout_route_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en, pll_en, lock_ovr, pll_locked;
    logic [1:0]  grp_div_en, grp_bypass, grp_clk_lvl;
    logic [10:0] out_en;
    logic        ref_clk_lvl;
    logic        pll_pwr_on, lock_status;
    logic [1:0]  grp_src_ref;
    logic [10:0] ch_src_ref, ch_en, ch_clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    clkout_route_ctl u0 (
        .clk(clk), .rst(rst), .chip_en(chip_en), .pll_en(pll_en), .lock_ovr(lock_ovr),
        .pll_locked(pll_locked), .grp_div_en(grp_div_en), .grp_bypass(grp_bypass),
        .out_en(out_en), .grp_clk_lvl(grp_clk_lvl), .ref_clk_lvl(ref_clk_lvl),
        .pll_pwr_on(pll_pwr_on), .lock_status(lock_status), .grp_src_ref(grp_src_ref),
        .ch_src_ref(ch_src_ref), .ch_en(ch_en), .ch_clk(ch_clk)
    );

    // {chip, pll_en, ovr, locked, div_en[1:0], bypass[1:0], out_en[10:0], expected ch_en[10:0]}
    localparam int NV = 9;
    localparam logic [29:0] VEC [NV] = '{
        {4'b1101, 2'b11, 2'b00, 11'h7FF, 11'h7FF},  // R4 all on, locked
        {4'b1100, 2'b11, 2'b00, 11'h7FF, 11'h400},  // R7 unlocked: groups off, direct on
        {4'b1110, 2'b11, 2'b00, 11'h7FF, 11'h7FF},  // R7 override
        {4'b1100, 2'b11, 2'b01, 11'h7FF, 11'h41F},  // R7 bypassed group 0 ungated
        {4'b1001, 2'b11, 2'b01, 11'h7FF, 11'h41F},  // R6 PLL off counts as unlocked
        {4'b0101, 2'b11, 2'b00, 11'h7FF, 11'h000},  // R5 chip off
        {4'b1101, 2'b10, 2'b00, 11'h7FF, 11'h7E0},  // R3 group 0 divider off
        {4'b1101, 2'b11, 2'b00, 11'h2A5, 11'h2A5},  // R4 per-output pattern
        {4'b1100, 2'b11, 2'b10, 11'h400, 11'h400}   // R1 direct only
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        chip_en = 1; pll_en = 1; lock_ovr = 0; pll_locked = 1;
        grp_div_en = 2'b11; grp_bypass = 2'b00; out_en = 11'h7FF;
        grp_clk_lvl = 2'b00; ref_clk_lvl = 1'b0;
        edges(3);
        // R11 reset state
        check("R11 ch_en", 32'(ch_en), 32'h0);
        check("R11 lock_status", 32'(lock_status), 32'h0);
        check("R11 grp_src_ref", 32'(grp_src_ref), 32'h0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [10:0] exp_src;
            {chip_en, pll_en, lock_ovr, pll_locked} = VEC[v][29:26];
            grp_div_en = VEC[v][25:24];
            grp_bypass = VEC[v][23:22];
            out_en     = VEC[v][21:11];
            edges(4);
            check("R3/R4/R5/R7 ch_en", 32'(ch_en), 32'(VEC[v][10:0]));
            exp_src = {1'b1, {5{grp_bypass[1]}}, {5{grp_bypass[0]}}};
            check("R2 ch_src_ref", 32'(ch_src_ref), 32'(exp_src));
            check("R6 pll_pwr_on", 32'(pll_pwr_on), 32'(chip_en & pll_en));
        end

        // back to defaults, locked
        chip_en = 1; pll_en = 1; lock_ovr = 0; pll_locked = 1;
        grp_div_en = 2'b11; grp_bypass = 2'b00; out_en = 11'h7FF;
        edges(4);
        check("R8 lock_status high", 32'(lock_status), 32'h1);
        pll_locked = 0;
        edges(1);
        check("R8 lock_status low after one edge", 32'(lock_status), 32'h0);
        pll_locked = 1;
        edges(4);

        // R2 three-step source change on group 1
        grp_bypass = 2'b10;
        edges(1);
        check("R2 edge1 group off", 32'(ch_en[9:5]), 32'h0);
        check("R2 edge1 select held", 32'(grp_src_ref[1]), 32'h0);
        edges(1);
        check("R2 edge2 select switched", 32'(grp_src_ref[1]), 32'h1);
        check("R2 edge2 group still off", 32'(ch_en[9:5]), 32'h0);
        edges(1);
        check("R2 edge3 group on", 32'(ch_en[9:5]), 32'h1F);
        check("R2 group 0 untouched", 32'(ch_en[4:0]), 32'h1F);

        // R9 enable change deferred while source is high
        grp_clk_lvl[0] = 1'b1;
        out_en[0] = 1'b0;
        edges(3);
        check("R9 held while source high", 32'(ch_en[0]), 32'h1);
        check("R10 enabled channel follows source", 32'(ch_clk[1]), 32'h1);
        grp_clk_lvl[0] = 1'b0;
        edges(1);
        check("R9 applied once source low", 32'(ch_en[0]), 32'h0);
        grp_clk_lvl[0] = 1'b1;
        ref_clk_lvl = 1'b1;
        @(posedge clk); #1;
        check("R10 disabled channel low", 32'(ch_clk[0]), 32'h0);
        check("R1 direct follows reference", 32'(ch_clk[10]), 32'h1);
        @(negedge clk);
        ref_clk_lvl = 1'b0; grp_clk_lvl = 2'b00;

        // R1 direct channel ignores lock and PLL enable
        pll_locked = 0; pll_en = 0;
        edges(3);
        check("R1 direct on without lock", 32'(ch_en[10]), 32'h1);
        check("R7 PLL group off without lock", 32'(ch_en[4:1]), 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule